// File: doc/BRIEF.md
# Three-Rail Power Sequencer Controller

This block switches three regulator enable flags on in the order rail 1, rail 2, rail 3 and off in the order rail 3, rail 2, rail 1. The gaps between flag changes are measured in periods of a slow timing tick that the surrounding chip supplies as a one-clock-wide pulse. A request input sets the direction. A polarity input chooses whether an active rail is driven high or low. The block runs entirely on the system clock.

When the request changes, the controller first waits for the next tick. It then counts nine more ticks before it moves the first flag, so the first gap lasts between nine and ten tick periods, depending on the phase of the request edge. Each later flag in the same direction follows exactly eight ticks after the previous one. If the request flips while a sequence is still running, the controller turns around from the rail where it stands. It applies the long first gap again before it moves the next flag in the new direction.

Top module: `rail_sequencer`

## Requirements
- R1: While reset is high, and afterwards while en_req stays low, no rail is active; down_done reads 1 and up_done reads 0.
- R2: After en_req rises, rail 1 turns active on the tenth tick pulse that follows the synchronized edge, which is nine to ten tick periods after the edge. This timing assumes the edge lands at least four clocks before the next pulse.
- R3: Going up, rail 2 turns active on the eighth tick pulse after rail 1 turned active, and rail 3 turns active on the eighth tick pulse after rail 2.
- R4: After en_req falls, rail 3 goes inactive on the tenth tick pulse. Rail 2 follows eight pulses after rail 3, and rail 1 follows eight pulses after rail 2.
- R5: flags[i] carries rail i+1 and equals its active state XOR invert. With invert low, an active rail reads 1. A change of invert shows on all flags within the same cycle.
- R6: Flags never change on a clock edge at which tick is low, so no timing advances without tick pulses.
- R7: A change of en_req during a sequence reverses the direction from the current rail, and the next change takes ten tick pulses. If no rail has yet moved in the cancelled direction, no flag changes.
- R8: up_done is 1 exactly when all three rails are active, and down_done is 1 exactly when none is active.
- R9: A synchronous reset during a sequence makes all rails inactive after the next clock edge and discards any delay in progress.
- R10: At most one rail changes per clock edge, and the set of active rails always consists of rail 1 up to some rail, with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Timing pulse, one clock wide |
| en_req | input | 1 | Power request, may be asynchronous |
| invert | input | 1 | Flag polarity: 1 means an active rail reads low |
| flags | output | RAILS (3) | Rail enable flags, bit 0 is rail 1 |
| up_done | output | 1 | All rails active |
| down_done | output | 1 | No rail active |

## Verification
The assertions rely on reset being high at the first clock edge and on tick never being high on two edges in a row. Under those conditions a rail can only move on a tick edge. The exact tick counts also require the request edge to land at least four clocks before a tick pulse, so that the synchronizer and the direction register have settled. The stimulus spaces pulses twenty clocks apart and changes en_req only a set number of clocks after a pulse, between two and fifteen, which keeps every request edge inside that safe window.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

   // Phases of one transition between two rail levels
   typedef enum logic [1:0] {
      ST_HOLD  = 2'd0,   // level matches the goal, nothing to do
      ST_ALIGN = 2'd1,   // waiting for the next tick after a direction change
      ST_FIRST = 2'd2,   // counting the long first gap
      ST_STEP  = 2'd3    // counting a regular gap between rails
   } seq_state_e;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pseq_sync.sv
module pseq_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (rst) chain <= RST_VAL;
            else     chain <= d;
         end
      end else begin : g_chain
         always_ff @(posedge clk) begin
            if (rst) chain <= {STAGES{RST_VAL}};
            else     chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/pseq_timer.sv
module pseq_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             tick,
   input  logic [CNT_W-1:0] limit,
   output logic             expire
);

   logic [CNT_W-1:0] cnt;

   // Fires on the tick that completes `limit` ticks since the last clear
   assign expire = tick && !clr && (cnt == (limit - CNT_W'(1)));

   always_ff @(posedge clk) begin
      if (rst || clr)  cnt <= '0;
      else if (expire) cnt <= '0;
      else if (tick)   cnt <= cnt + CNT_W'(1);
   end

endmodule

// File: rtl/pseq_ctrl.sv
module pseq_ctrl
   import pseq_pkg::*;
#(
   parameter int RAILS       = 3,
   parameter int FIRST_TICKS = 9,
   parameter int STEP_TICKS  = 8,
   parameter int LVL_W       = 2,
   parameter int CNT_W       = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             en_s,
   input  logic             expire,
   output logic             timer_clr,
   output logic [CNT_W-1:0] timer_limit,
   output logic [LVL_W-1:0] level
);

   localparam logic [LVL_W-1:0] LVL_TOP = LVL_W'(RAILS);

   seq_state_e       state, state_n;
   logic             goal, goal_n;
   logic [LVL_W-1:0] level_n;
   logic             restart;
   logic             new_at_end;
   logic             last_move;

   assign restart    = (en_s != goal);
   assign new_at_end = en_s ? (level == LVL_TOP) : (level == '0);
   assign last_move  = goal ? (level == LVL_TOP - LVL_W'(1))
                            : (level == LVL_W'(1));

   always_comb begin
      state_n = state;
      goal_n  = goal;
      level_n = level;
      if (restart) begin
         goal_n  = en_s;
         state_n = new_at_end ? ST_HOLD : ST_ALIGN;
      end else begin
         unique case (state)
            ST_HOLD:  state_n = ST_HOLD;
            ST_ALIGN: if (tick) state_n = ST_FIRST;
            ST_FIRST,
            ST_STEP: begin
               if (expire) begin
                  level_n = goal ? (level + LVL_W'(1)) : (level - LVL_W'(1));
                  state_n = last_move ? ST_HOLD : ST_STEP;
               end
            end
            default: state_n = ST_HOLD;
         endcase
      end
   end

   assign timer_clr   = restart || (state == ST_HOLD) || (state == ST_ALIGN);
   assign timer_limit = (state == ST_FIRST) ? CNT_W'(FIRST_TICKS)
                                            : CNT_W'(STEP_TICKS);

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_HOLD;
         goal  <= 1'b0;
         level <= '0;
      end else begin
         state <= state_n;
         goal  <= goal_n;
         level <= level_n;
      end
   end

endmodule

// File: rtl/pseq_drive.sv
module pseq_drive #(
   parameter int RAILS = 3,
   parameter int LVL_W = 2
) (
   input  logic [LVL_W-1:0] level,
   input  logic             invert,
   output logic [RAILS-1:0] flags,
   output logic             all_on,
   output logic             all_off
);

   generate
      for (genvar i = 0; i < RAILS; i++) begin : g_rail
         assign flags[i] = (level > LVL_W'(i)) ^ invert;
      end
   endgenerate

   assign all_on  = (level == LVL_W'(RAILS));
   assign all_off = (level == '0);

endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer #(
   parameter int RAILS       = 3,
   parameter int FIRST_TICKS = 9,
   parameter int STEP_TICKS  = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             en_req,
   input  logic             invert,
   output logic [RAILS-1:0] flags,
   output logic             up_done,
   output logic             down_done
);

   localparam int LVL_W = $clog2(RAILS + 1);
   localparam int CNT_W = $clog2(pseq_pkg::max_int(FIRST_TICKS, STEP_TICKS) + 1);

   generate
      if (RAILS < 1) begin : g_bad_rails
         $error("rail_sequencer: RAILS must be at least 1");
      end
      if (FIRST_TICKS < 1 || STEP_TICKS < 1) begin : g_bad_ticks
         $error("rail_sequencer: tick counts must be at least 1");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("rail_sequencer: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic             en_s;
   logic             expire;
   logic             timer_clr;
   logic [CNT_W-1:0] timer_limit;
   logic [LVL_W-1:0] level;

   pseq_sync #(
      .STAGES (SYNC_STAGES),
      .RST_VAL(1'b0)
   ) u_sync (
      .clk(clk),
      .rst(rst),
      .d  (en_req),
      .q  (en_s)
   );

   pseq_timer #(
      .CNT_W(CNT_W)
   ) u_timer (
      .clk   (clk),
      .rst   (rst),
      .clr   (timer_clr),
      .tick  (tick),
      .limit (timer_limit),
      .expire(expire)
   );

   pseq_ctrl #(
      .RAILS      (RAILS),
      .FIRST_TICKS(FIRST_TICKS),
      .STEP_TICKS (STEP_TICKS),
      .LVL_W      (LVL_W),
      .CNT_W      (CNT_W)
   ) u_ctrl (
      .clk        (clk),
      .rst        (rst),
      .tick       (tick),
      .en_s       (en_s),
      .expire     (expire),
      .timer_clr  (timer_clr),
      .timer_limit(timer_limit),
      .level      (level)
   );

   pseq_drive #(
      .RAILS(RAILS),
      .LVL_W(LVL_W)
   ) u_drive (
      .level  (level),
      .invert (invert),
      .flags  (flags),
      .all_on (up_done),
      .all_off(down_done)
   );

endmodule

// File: rtl/rail_sequencer_chk.sv
module rail_sequencer_chk #(
   parameter int RAILS = 3
) (
   input logic             clk,
   input logic             rst,
   input logic             tick,
   input logic             invert,
   input logic [RAILS-1:0] flags,
   input logic             up_done,
   input logic             down_done
);

   logic [RAILS-1:0] act;
   assign act = flags ^ {RAILS{invert}};

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (act == '0));

   // R6
   tick_gate_chk: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(act));

   // R10
   thermo_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot({1'b0, act} + (RAILS+1)'(1)));

   // R10
   single_step_chk: assert property (@(posedge clk) disable iff (rst)
      !rst |=> ($countones(act ^ $past(act)) <= 1));

   // R8
   up_status_chk: assert property (@(posedge clk) disable iff (rst)
      up_done == (&act));

   // R8
   down_status_chk: assert property (@(posedge clk) disable iff (rst)
      down_done == (act == '0));

endmodule

bind rail_sequencer rail_sequencer_chk #(.RAILS(RAILS)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .tick     (tick),
   .invert   (invert),
   .flags    (flags),
   .up_done  (up_done),
   .down_done(down_done)
);

// File: tb/rail_sequencer_test.sv
module rail_sequencer_test;

   localparam int TPER      = 20;  // clocks between tick pulses
   localparam int EXP_FIRST = 10;  // pulses to first change
   localparam int EXP_STEP  = 8;   // pulses between later changes
   localparam int NVEC      = 6;
   // {invert, offset in clocks after a tick at which en_req changes}
   localparam logic [7:0] VEC [NVEC] = '{
      {1'b0, 7'd2}, {1'b1, 7'd5}, {1'b0, 7'd9},
      {1'b1, 7'd12}, {1'b0, 7'd15}, {1'b1, 7'd3}
   };

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       tick = 1'b0;
   logic       en_req = 1'b0;
   logic       invert = 1'b0;
   logic [2:0] flags;
   logic       up_done, down_done;
   bit         tick_run = 1'b1;
   int         checks = 0;
   int         fails = 0;

   always #10 clk = ~clk;

   rail_sequencer uut (
      .clk(clk), .rst(rst), .tick(tick), .en_req(en_req), .invert(invert),
      .flags(flags), .up_done(up_done), .down_done(down_done)
   );

   initial begin
      forever begin
         repeat (TPER - 1) @(negedge clk);
         if (tick_run) tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
      end
   end

   function automatic logic [2:0] act();
      return flags ^ {3{invert}};
   endfunction

   task automatic check(input string req, input int got, input int exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic align_en(input bit val, input int off);
      wait (tick === 1'b1);
      @(posedge clk);
      repeat (off) @(negedge clk);
      en_req = val;
   endtask

   task automatic skip_ticks(input int n);
      for (int k = 0; k < n; k++) begin
         wait (tick === 1'b1);
         @(posedge clk);
      end
   endtask

   task automatic wait_change(input string req, input int exp_mask, input int exp_pulses);
      logic [2:0] prev, cur;
      int pulses;
      logic t;
      prev = act();
      cur = prev;
      pulses = 0;
      for (int c = 0; c < 600; c++) begin
         @(posedge clk);
         t = tick;
         #2;
         if (t) pulses++;
         cur = act();
         if (cur !== prev) break;
      end
      check({req, " R10 changed rail"}, int'(cur ^ prev), exp_mask);
      check({req, " tick count"}, pulses, exp_pulses);
   endtask

   task automatic run_seq(input bit up);
      for (int s = 0; s < 3; s++) begin
         int idx;
         idx = up ? s : 2 - s;
         if (up) wait_change((s == 0) ? "R2" : "R3", 1 << idx, (s == 0) ? EXP_FIRST : EXP_STEP);
         else    wait_change("R4", 1 << idx, (s == 0) ? EXP_FIRST : EXP_STEP);
      end
   endtask

   task automatic observe_quiet(input string req, input int cycles);
      int bad;
      bad = 0;
      for (int c = 0; c < cycles; c++) begin
         @(posedge clk);
         #2;
         if (act() !== 3'b000) bad++;
      end
      check(req, bad, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (5) @(posedge clk);
      #2;
      check("R1 flags in reset", int'(act()), 0);
      check("R1 down_done", int'(down_done), 1);
      check("R1 up_done", int'(up_done), 0);
      @(negedge clk);
      rst = 1'b0;
      observe_quiet("R1 idle with en low", 5 * TPER);

      // table walk: full up then down sequences
      for (int v = 0; v < NVEC; v++) begin
         @(negedge clk);
         invert = VEC[v][7];
         #1;
         check("R5 inactive polarity", int'(flags), {3{VEC[v][7]}});
         align_en(1'b1, int'(VEC[v][6:0]));
         run_seq(1'b1);
         check("R8 up_done", int'(up_done), 1);
         check("R5 active polarity", int'(flags), {3{~VEC[v][7]}});
         align_en(1'b0, int'(VEC[v][6:0]));
         run_seq(1'b0);
         check("R8 down_done", int'(down_done), 1);
         check("R8 up_done low", int'(up_done), 0);
      end

      // R6: no progress without tick pulses
      @(negedge clk);
      invert = 1'b0;
      tick_run = 1'b0;
      en_req = 1'b1;
      repeat (300) @(posedge clk);
      #2;
      check("R6 no ticks no change", int'(act()), 0);
      @(negedge clk);
      tick_run = 1'b1;
      run_seq(1'b1);

      // R5: runtime polarity change
      @(negedge clk);
      invert = 1'b1;
      #1;
      check("R5 invert flip", int'(flags), 0);
      @(negedge clk);
      invert = 1'b0;
      #1;
      check("R5 invert restore", int'(flags), 7);

      // R7: reversal mid-sequence
      align_en(1'b0, 5);
      wait_change("R7 down from top", 3'b100, EXP_FIRST);
      skip_ticks(2);
      align_en(1'b1, 5);
      wait_change("R7 reversed up", 3'b100, EXP_FIRST);
      check("R7 up_done after reversal", int'(up_done), 1);
      align_en(1'b0, 7);
      run_seq(1'b0);

      // R7: cancelled request before any rail moved
      align_en(1'b1, 3);
      align_en(1'b0, 3);
      observe_quiet("R7 cancelled request", 15 * TPER);

      // R9: reset during a sequence
      align_en(1'b1, 4);
      wait_change("R9 setup", 3'b001, EXP_FIRST);
      skip_ticks(3);
      @(negedge clk);
      en_req = 1'b0;
      rst = 1'b1;
      @(posedge clk);
      #2;
      check("R9 reset clears rails", int'(act()), 0);
      check("R9 down_done", int'(down_done), 1);
      @(negedge clk);
      rst = 1'b0;
      observe_quiet("R9 stays down", 12 * TPER);

      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule